// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Flag Register

This block is the arithmetic and logic unit of a small accumulator-based processor core. It owns the accumulator and the flag byte. A start pulse captures two operands. The second operand comes from the internal data bus into an operand hold register. The first operand is a copy of the accumulator, taken into an accumulator hold register. One clock later the block computes the result and the new flags from those held values and writes both back.

Ten operations are selected by a four-bit code: add, add with carry, subtract, subtract with borrow, increment, decrement, AND, OR, XOR and compare. Compare subtracts only to produce flags and leaves the accumulator as it was. A separate load strobe puts a bus value straight into the accumulator.

Operations can be issued on consecutive cycles. When an operation starts while the previous one is writing back, the new accumulator copy is taken from the result being written, so chained operations see the updated value.

Top module: `acc_alu8`

## Requirements
- R1: After reset, while rst_n is low and after it rises, acc_out is 0x00 and flags_out is 0x00.
- R2: A start pulse at one rising edge captures bus_data and the accumulator. The result and flags appear on acc_out and flags_out after the next rising edge. A lone acc_load puts bus_data into the accumulator at its rising edge and leaves the flags unchanged.
- R3: The op codes are 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 INC, 5 DEC, 6 AND, 7 OR, 8 XOR and 9 CP. ADD and ADC produce the 8-bit sum, with ADC adding the current carry flag. Carry is set on a carry out of bit 7.
- R4: SUB and SBC produce accumulator minus operand, with SBC also subtracting the current carry flag. Carry is set when a borrow out of bit 7 occurs.
- R5: INC and DEC add or subtract one from the accumulator and ignore bus_data. They leave the carry flag at its previous value.
- R6: AND, OR and XOR clear carry and half-carry. For these operations bit 2 is 1 exactly when the result has an even number of one bits.
- R7: CP sets every flag as SUB would, and the accumulator keeps its value.
- R8: The flag byte layout is sign at bit 7, zero at bit 6, half-carry at bit 4, parity/overflow at bit 2, subtract at bit 1 and carry at bit 0. Bits 5 and 3 always read 0. Sign equals bit 7 of the result, and zero is 1 when the 8-bit result is 0x00.
- R9: Half-carry is set on a carry from bit 3 into bit 4 for additions (ADD, ADC, INC), or on a borrow from bit 4 into bit 3 for subtractions (SUB, SBC, DEC, CP).
- R10: For ADD, ADC, SUB, SBC, CP, INC and DEC, bit 2 is set on two's-complement signed overflow.
- R11: The subtract flag is set after SUB, SBC, CP and DEC, and cleared after ADD, ADC, INC, AND, OR and XOR.
- R12: A start in the cycle in which the previous operation writes back uses that operation's result as the accumulator operand. For CP or an unused code, the accumulator operand is the unchanged accumulator.
- R13: When acc_load is high at the edge where an operation writes the accumulator, the operation result wins and the load is dropped. During a CP write-back, the load is applied.
- R14: Op codes 10 to 15 change neither the accumulator nor the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation: capture operands and op code |
| op | input | 4 | Operation code, sampled with start |
| bus_data | input | 8 | Internal data bus: second operand or load value |
| acc_load | input | 1 | Write bus_data into the accumulator |
| acc_out | output | 8 | Accumulator contents |
| flags_out | output | 8 | Flag byte |

## Verification
The interesting overlap is a new start, or an accumulator load, in the same cycle as a write-back. The bench provokes the first with two additions issued on successive cycles. The second must return the twice-incremented value, which shows the captured accumulator copy was taken from the result in flight. It provokes the second by raising acc_load during the write-back edge of an ADD, where the sum must survive, and of a CP, where the loaded value must appear with the compare flags.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    parameter int unsigned DW   = 8;
    parameter int unsigned OPW  = 4;

    localparam int unsigned F_SIGN = 7;
    localparam int unsigned F_ZERO = 6;
    localparam int unsigned F_HALF = 4;
    localparam int unsigned F_PV   = 2;
    localparam int unsigned F_SUBT = 1;
    localparam int unsigned F_CARY = 0;

    typedef enum logic [OPW-1:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_INC = 4'd4,
        OP_DEC = 4'd5,
        OP_AND = 4'd6,
        OP_OR  = 4'd7,
        OP_XOR = 4'd8,
        OP_CP  = 4'd9
    } alu_op_e;

    typedef struct packed {
        logic [DW-1:0]  acu;
        logic [DW-1:0]  tmp;
        logic [OPW-1:0] code;
        logic           exec;
    } hold_t;

    typedef struct packed {
        logic [DW-1:0] acc;
        logic [DW-1:0] flags;
    } arch_t;
endpackage

// File: rtl/alu8_hold.sv
module alu8_hold
    import alu8_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [OPW-1:0] op,
    input  logic [DW-1:0]  bus_data,
    input  logic [DW-1:0]  acc_now,
    input  logic           fwd_en,
    input  logic [DW-1:0]  fwd_val,
    output hold_t          hold
);
    hold_t hold_d, hold_q;

    always_comb begin
        hold_d      = hold_q;
        hold_d.exec = start;
        if (start) begin
            hold_d.tmp  = bus_data;
            hold_d.code = op;
            hold_d.acu  = fwd_en ? fwd_val : acc_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign hold = hold_q;
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  hold_t          hold,
    input  logic           carry_now,
    output logic [DW-1:0]  result,
    output logic [DW-1:0]  flags_new,
    output logic           known_op,
    output logic           writes_acc
);
    localparam int unsigned NW = DW / 2;

    logic [DW:0]   wide;
    logic [NW:0]   nib;
    logic [DW-1:0] a, b;
    logic          cin, half, pv, subt, cy, is_sub, is_add, is_logic;

    always_comb begin
        a        = hold.acu;
        b        = hold.tmp;
        cin      = 1'b0;
        is_add   = 1'b0;
        is_sub   = 1'b0;
        is_logic = 1'b0;
        known_op = 1'b1;
        result   = '0;
        case (hold.code)
            OP_ADD: is_add = 1'b1;
            OP_ADC: begin is_add = 1'b1; cin = carry_now; end
            OP_INC: begin is_add = 1'b1; b = {{(DW-1){1'b0}}, 1'b1}; end
            OP_SUB, OP_CP: is_sub = 1'b1;
            OP_SBC: begin is_sub = 1'b1; cin = carry_now; end
            OP_DEC: begin is_sub = 1'b1; b = {{(DW-1){1'b0}}, 1'b1}; end
            OP_AND, OP_OR, OP_XOR: is_logic = 1'b1;
            default: known_op = 1'b0;
        endcase

        wide = '0;
        nib  = '0;
        if (is_add) begin
            wide = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
            nib  = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin};
        end else if (is_sub) begin
            wide = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cin};
            nib  = {1'b0, a[NW-1:0]} - {1'b0, b[NW-1:0]} - {{NW{1'b0}}, cin};
        end

        if (is_logic) begin
            unique case (hold.code)
                OP_AND:  result = a & b;
                OP_OR:   result = a | b;
                default: result = a ^ b;
            endcase
        end else begin
            result = wide[DW-1:0];
        end

        half = nib[NW];
        cy   = wide[DW];
        pv   = 1'b0;
        if (is_add) begin
            pv = (a[DW-1] == b[DW-1]) && (result[DW-1] != a[DW-1]);
        end else if (is_sub) begin
            pv = (a[DW-1] != b[DW-1]) && (result[DW-1] != a[DW-1]);
        end else if (is_logic) begin
            pv   = ~(^result);
            half = 1'b0;
            cy   = 1'b0;
        end
        if (hold.code == OP_INC || hold.code == OP_DEC) begin
            cy = carry_now;
        end
        subt = is_sub;

        flags_new         = '0;
        flags_new[F_SIGN] = result[DW-1];
        flags_new[F_ZERO] = (result == '0);
        flags_new[F_HALF] = half;
        flags_new[F_PV]   = pv;
        flags_new[F_SUBT] = subt;
        flags_new[F_CARY] = cy;

        writes_acc = known_op && (hold.code != OP_CP);
    end
endmodule

// File: rtl/acc_alu8.sv
module acc_alu8
    import alu8_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [OPW-1:0] op,
    input  logic [DW-1:0]  bus_data,
    input  logic           acc_load,
    output logic [DW-1:0]  acc_out,
    output logic [DW-1:0]  flags_out
);
    arch_t         arch_d, arch_q;
    hold_t         hold;
    logic [DW-1:0] result, flags_new;
    logic          known_op, writes_acc, wb_acc;
    logic          exec_w;
    logic [OPW-1:0] code_w;

    alu8_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op       (op),
        .bus_data (bus_data),
        .acc_now  (arch_q.acc),
        .fwd_en   (wb_acc),
        .fwd_val  (result),
        .hold     (hold)
    );

    alu8_core u_core (
        .hold       (hold),
        .carry_now  (arch_q.flags[F_CARY]),
        .result     (result),
        .flags_new  (flags_new),
        .known_op   (known_op),
        .writes_acc (writes_acc)
    );

    assign wb_acc = hold.exec && writes_acc;
    assign exec_w = hold.exec;
    assign code_w = hold.code;

    always_comb begin
        arch_d = arch_q;
        if (hold.exec && known_op) begin
            arch_d.flags = flags_new;
        end
        if (wb_acc) begin
            arch_d.acc = result;
        end else if (acc_load) begin
            arch_d.acc = bus_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arch_q <= '0;
        end else begin
            arch_q <= arch_d;
        end
    end

    assign acc_out   = arch_q.acc;
    assign flags_out = arch_q.flags;
endmodule

// File: rtl/alu8_checker.sv
module alu8_checker
    import alu8_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           acc_load,
    input logic           exec_w,
    input logic [OPW-1:0] code_w,
    input logic [DW-1:0]  acc_out,
    input logic [DW-1:0]  flags_out
);
    logic wr_op;
    assign wr_op = exec_w && (code_w <= 4'd8);

    p_spare_bits_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flags_out[5] == 1'b0 && flags_out[3] == 1'b0);

    p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_op |=> flags_out[F_ZERO] == (acc_out == '0));

    p_sign_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_op |=> flags_out[F_SIGN] == acc_out[DW-1]);

    p_cp_keeps_acc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_w && code_w == 4'd9 && !acc_load) |=> $stable(acc_out));

    p_incdec_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_w && (code_w == 4'd4 || code_w == 4'd5)) |=> $stable(flags_out[F_CARY]));

    p_subt_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_w && (code_w == 4'd2 || code_w == 4'd3 || code_w == 4'd5 || code_w == 4'd9))
        |=> flags_out[F_SUBT]);

    p_subt_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_w && (code_w <= 4'd1 || code_w == 4'd4 || (code_w >= 4'd6 && code_w <= 4'd8)))
        |=> !flags_out[F_SUBT]);

    p_logic_no_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_w && code_w >= 4'd6 && code_w <= 4'd8)
        |=> !flags_out[F_CARY] && !flags_out[F_HALF]);

    p_unused_code_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_w && code_w >= 4'd10 && !acc_load) |=> $stable(acc_out) && $stable(flags_out));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec_w && !acc_load) |=> $stable(acc_out) && $stable(flags_out));
endmodule

bind acc_alu8 alu8_checker i_alu8_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_load  (acc_load),
    .exec_w    (exec_w),
    .code_w    (code_w),
    .acc_out   (acc_out),
    .flags_out (flags_out)
);

// File: tb/test_acc_alu8.sv
`timescale 1ns/1ps
module test_acc_alu8;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] op = 4'd0;
    logic [7:0] bus_data = 8'h00;
    logic       acc_load = 1'b0;
    logic [7:0] acc_out, flags_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    acc_alu8 i_acc_alu8 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op        (op),
        .bus_data  (bus_data),
        .acc_load  (acc_load),
        .acc_out   (acc_out),
        .flags_out (flags_out)
    );

    // {initial acc, op, operand, expected acc, expected flags}
    localparam int NV = 17;
    localparam logic [35:0] VEC [NV] = '{
        {8'h0F, 4'd0, 8'h01, 8'h10, 8'h10},  // R3 R9 ADD half-carry
        {8'hFF, 4'd0, 8'h01, 8'h00, 8'h51},  // R3 R8 carry out, zero
        {8'h10, 4'd1, 8'h20, 8'h31, 8'h00},  // R3 ADC uses carry=1
        {8'h7F, 4'd0, 8'h01, 8'h80, 8'h94},  // R10 signed overflow
        {8'h05, 4'd2, 8'h07, 8'hFE, 8'h93},  // R4 borrow
        {8'h10, 4'd3, 8'h01, 8'h0E, 8'h12},  // R4 SBC with carry=1
        {8'h80, 4'd2, 8'h01, 8'h7F, 8'h16},  // R10 sub overflow
        {8'h42, 4'd9, 8'h42, 8'h42, 8'h42},  // R7 CP equal
        {8'hF0, 4'd6, 8'h3C, 8'h30, 8'h04},  // R6 AND even parity
        {8'hF0, 4'd7, 8'h01, 8'hF1, 8'h80},  // R6 OR odd parity
        {8'hAA, 4'd8, 8'hAA, 8'h00, 8'h44},  // R6 XOR zero
        {8'hFF, 4'd0, 8'h01, 8'h00, 8'h51},  // set carry
        {8'h7F, 4'd4, 8'h55, 8'h80, 8'h95},  // R5 INC keeps carry
        {8'h00, 4'd5, 8'h55, 8'hFF, 8'h93},  // R5 R11 DEC
        {8'h80, 4'd5, 8'h00, 8'h7F, 8'h17},  // R10 DEC overflow
        {8'h00, 4'd3, 8'h00, 8'hFF, 8'h93},  // R4 SBC 0-0-1
        {8'h12, 4'd15, 8'h34, 8'h12, 8'h93}  // R14 unused code
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic load_acc(input logic [7:0] v);
        @(negedge clk);
        acc_load = 1'b1;
        bus_data = v;
        @(negedge clk);
        acc_load = 1'b0;
    endtask

    task automatic issue(input logic [3:0] code, input logic [7:0] v);
        start    = 1'b1;
        op       = code;
        bus_data = v;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #1;
        check("R1 acc in reset", acc_out, 8'h00);
        check("R1 flags in reset", flags_out, 8'h00);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 acc after reset", acc_out, 8'h00);
        check("R1 flags after reset", flags_out, 8'h00);

        for (int i = 0; i < NV; i++) begin
            load_acc(VEC[i][35:28]);
            issue(VEC[i][27:24], VEC[i][23:16]);
            @(negedge clk);
            check($sformatf("R2 vector %0d acc", i), acc_out, VEC[i][15:8]);
            check($sformatf("R8 vector %0d flags", i), flags_out, VEC[i][7:0]);
        end

        // R2: lone load leaves flags
        load_acc(8'hC3);
        check("R2 load acc", acc_out, 8'hC3);
        check("R2 load keeps flags", flags_out, 8'h93);

        // R12: back-to-back adds forward the result
        load_acc(8'h01);
        start = 1'b1; op = 4'd0; bus_data = 8'h01;
        @(negedge clk);
        start = 1'b1; op = 4'd0; bus_data = 8'h01;
        @(negedge clk);
        start = 1'b0;
        check("R12 first result mid-chain", acc_out, 8'h02);
        @(negedge clk);
        check("R12 forwarded chain acc", acc_out, 8'h03);
        check("R12 forwarded chain flags", flags_out, 8'h00);

        // R13: write-back beats a load
        load_acc(8'h01);
        start = 1'b1; op = 4'd0; bus_data = 8'h02;
        @(negedge clk);
        start = 1'b0; acc_load = 1'b1; bus_data = 8'h77;
        @(negedge clk);
        acc_load = 1'b0;
        check("R13 result wins over load", acc_out, 8'h03);

        // R13 R7: load during a CP write-back is applied
        start = 1'b1; op = 4'd9; bus_data = 8'h03;
        @(negedge clk);
        start = 1'b0; acc_load = 1'b1; bus_data = 8'h55;
        @(negedge clk);
        acc_load = 1'b0;
        check("R13 load applied during CP", acc_out, 8'h55);
        check("R7 CP flags", flags_out, 8'h42);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule